// File: doc/BRIEF.md
# Offset Min-Sum Check Node Unit

This block works out the check-to-variable messages for one parity-check row of a quasi-cyclic LDPC decoder, using the offset min-sum rule. Variable-to-check messages for one row arrive one per cycle, framed by a first-edge flag and a last-edge flag. While they arrive, the block keeps four things: the smallest magnitude, the second smallest magnitude, the position of the smallest, and the XOR of all signs. It also stores one sign bit per edge.

After the last edge, the block sends one outgoing message per edge, in edge order, one per cycle. Each message is the minimum magnitude over the other edges, reduced by an offset that depends on the code rate and clamped at zero. Its sign is the parity of the other edges' signs.

A 2-bit mode input picks the rate and so the offset, and is sampled on the first edge of each row. All messages are 6-bit two's-complement values with two fractional bits, so one unit is 0.25. The largest row degree is set by the parameter `MAX_DEG`. Rows of degree 1 to `MAX_DEG` are supported.

Top module: `ldpc_cnu_oms`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low and stay low until a row ends.
- R2: An input is 6-bit two's complement, with bit 5 as the sign. Its magnitude is its absolute value, and the code -32 saturates to magnitude 31.
- R3: For edge k, the output magnitude is the smallest input magnitude among the other edges of the row, minus the offset, clamped at zero. For a row of one edge, that minimum is taken as 31.
- R4: For edge k, the output sign is the XOR of the sign bits of the other edges. A zero input counts as positive. The output is two's complement, a zero magnitude is always the code 0, and the code -32 never appears.
- R5: The offset in quarter units follows the mode: mode 0 gives 2 (rate 1/2), mode 1 gives 3 (rate 3/4), mode 2 gives 4 (rate 7/8), and mode 3 gives 0. The mode is taken only in the cycle of the first edge. A change on later edges of the same row has no effect.
- R6: The first output appears in the cycle right after the last edge is accepted. Outputs come one per cycle in input order, one per edge, and `out_last` marks the final one. `out_valid` is low in the following cycle.
- R7: While outputs are being sent, every input is ignored: `in_valid`, `in_first`, `in_last`, `in_msg` and `mode`.
- R8: When the smallest magnitude appears on more than one edge, every edge of the row receives that smallest magnitude, reduced by the offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Rate select, sampled on the first edge |
| in_valid | input | 1 | Input message strobe |
| in_first | input | 1 | Marks the first edge of a row |
| in_last | input | 1 | Marks the last edge of a row |
| in_msg | input | 6 | Variable-to-check message |
| out_valid | output | 1 | Output message strobe |
| out_last | output | 1 | Marks the final output of a row |
| out_msg | output | 6 | Check-to-variable message |

## Verification
On every cycle, the assertions check the framing of the output burst. A row end starts the burst, the burst runs without gaps and stops right after `out_last`, the negative extreme code is never sent, the latched offset does not move during a burst, and the stored first minimum never exceeds the second.

The bench alone can show the numeric results. It compares each message with a model that takes the minimum and the sign parity over the other edges directly. The rows it sends cover random values, ties of the smallest magnitude, the saturating code -32, zero inputs, every degree from 1 up to the maximum, and all four modes.

Only the bench shows that a mode change after the first edge, and any input given during a burst, leave the results unchanged.

// File: rtl/ldpc_cnu_oms.sv
module ldpc_cnu_oms #(
  parameter int MAX_DEG = 8,
  parameter int MW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          in_last,
  input  logic [MW-1:0] in_msg,
  output logic          out_valid,
  output logic          out_last,
  output logic [MW-1:0] out_msg
);
  localparam int PW = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1;
  localparam int CW = $clog2(MAX_DEG + 1);
  localparam logic [MW-2:0] MAXMAG = '1;
  localparam logic [MW-1:0] NEGMAX = {1'b1, {(MW-1){1'b0}}};

  logic               emitting;
  logic [CW-1:0]      cnt, deg;
  logic [PW-1:0]      ptr, idx1;
  logic [MW-2:0]      min1, min2, off;
  logic               par;
  logic [MAX_DEG-1:0] signs;

  function automatic logic [MW-2:0] rate_off(input logic [1:0] m);
    case (m)
      2'd0:    return (MW-1)'(2);
      2'd1:    return (MW-1)'(3);
      2'd2:    return (MW-1)'(4);
      default: return '0;
    endcase
  endfunction

  wire take = in_valid && !emitting;
  wire [CW-1:0] base = in_first ? '0 : cnt;
  wire room = base < CW'(MAX_DEG);
  wire [PW-1:0] slot = base[PW-1:0];
  wire [MW-2:0] b1 = in_first ? MAXMAG : min1;
  wire [MW-2:0] b2 = in_first ? MAXMAG : min2;
  wire bpar = in_first ? 1'b0 : par;
  wire in_neg = in_msg[MW-1];
  wire [MW-1:0] negated = -in_msg;
  wire [MW-2:0] in_mag = !in_neg ? in_msg[MW-2:0] :
                         (in_msg == NEGMAX) ? MAXMAG : negated[MW-2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emitting <= 1'b0;
      cnt <= '0;
      deg <= '0;
      ptr <= '0;
      idx1 <= '0;
      min1 <= MAXMAG;
      min2 <= MAXMAG;
      off <= '0;
      par <= 1'b0;
      signs <= '0;
    end else if (take) begin
      if (in_first) off <= rate_off(mode);
      if (room) begin
        signs[slot] <= in_neg;
        par <= bpar ^ in_neg;
        if (in_mag < b1) begin
          min1 <= in_mag;
          min2 <= b1;
          idx1 <= slot;
        end else begin
          min1 <= b1;
          min2 <= (in_mag < b2) ? in_mag : b2;
        end
        cnt <= base + CW'(1);
      end
      if (in_last) begin
        emitting <= 1'b1;
        ptr <= '0;
        deg <= room ? base + CW'(1) : base;
      end
    end else if (emitting) begin
      if (CW'(ptr) == deg - CW'(1)) begin
        emitting <= 1'b0;
        cnt <= '0;
        min1 <= MAXMAG;
        min2 <= MAXMAG;
        par <= 1'b0;
      end else begin
        ptr <= ptr + PW'(1);
      end
    end
  end

  wire [MW-2:0] pick = (ptr == idx1) ? min2 : min1;
  wire [MW-2:0] mag = (pick > off) ? pick - off : '0;
  wire osgn = par ^ signs[ptr];

  assign out_valid = emitting;
  assign out_last = emitting && (CW'(ptr) == deg - CW'(1));
  assign out_msg = osgn ? -{1'b0, mag} : {1'b0, mag};

  // R4
  no_negmax_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_msg != NEGMAX);
  // R6
  last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);
  // R6
  start_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && !out_valid) |=> out_valid);
  // R6
  burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);
  // R7
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> $stable(off));
  // R8
  min_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    min1 <= min2);
endmodule

// File: tb/tb_ldpc_cnu_oms.sv
module tb_ldpc_cnu_oms;
  localparam int MAX_DEG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [5:0] in_msg = '0;
  logic out_valid, out_last;
  logic [5:0] out_msg;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  int rv[MAX_DEG];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  ldpc_cnu_oms #(.MAX_DEG(MAX_DEG), .MW(6)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
    .in_first(in_first), .in_last(in_last), .in_msg(in_msg),
    .out_valid(out_valid), .out_last(out_last), .out_msg(out_msg)
  );

  always #2 clk = ~clk;

  function automatic int rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    lfsr = lfsr ^ (lfsr << 7);
    return int'(lfsr & 32'h7FFF_FFFF);
  endfunction

  function automatic int sat_mag(int v);
    if (v == -32) return 31;
    return (v < 0) ? -v : v;
  endfunction

  function automatic int offset_of(int md);
    case (md)
      0: return 2;
      1: return 3;
      2: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int expect_msg(int deg, int k, int off);
    int m = 31;
    int s = 0;
    int mg;
    for (int j = 0; j < deg; j++) begin
      if (j != k) begin
        if (sat_mag(rv[j]) < m) m = sat_mag(rv[j]);
        if (rv[j] < 0) s ^= 1;
      end
    end
    mg = (m > off) ? m - off : 0;
    return (s != 0) ? -mg : mg;
  endfunction

  task automatic check(string tag, int act, int exp, int k);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s edge %0d actual %0d expected %0d", tag, k, act, exp);
    end
  endtask

  task automatic run_row(int deg, int md, int kind);
    string tag;
    int base;
    base = (rnd() % 63) - 31;
    for (int i = 0; i < deg; i++) begin
      case (kind)
        1: rv[i] = (i % 2 == 0) ? base : -base;
        2: rv[i] = (rnd() % 3 == 0) ? -32 : (rnd() % 64) - 32;
        3: rv[i] = (i == 1 || i == deg - 1) ? 1 : 2 + rnd() % 30;
        4: rv[i] = (rnd() % 2 == 0) ? 0 : (rnd() % 64) - 32;
        default: rv[i] = (rnd() % 64) - 32;
      endcase
    end
    if (kind == 1 || kind == 3) tag = "R8 tie";
    else if (kind == 2) tag = "R2 saturate";
    else tag = "R3/R4/R5 message";
    for (int i = 0; i < deg; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_first = (i == 0);
      in_last = (i == deg - 1);
      in_msg = 6'(rv[i]);
      mode = (i == 0) ? 2'(md) : 2'(rnd());
    end
    for (int k = 0; k < deg; k++) begin
      @(negedge clk);
      // R7: random inputs during the burst must not disturb it
      in_valid = 1'b1;
      in_first = rnd() % 2 == 0;
      in_last = rnd() % 2 == 0;
      in_msg = 6'(rnd());
      mode = 2'(rnd());
      check("R6 valid", int'(out_valid), 1, k);
      check("R6 last", int'(out_last), (k == deg - 1) ? 1 : 0, k);
      check(tag, int'($signed(out_msg)), expect_msg(deg, k, offset_of(md)), k);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last = 1'b0;
    check("R6 drop", int'(out_valid), 0, deg);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset valid", int'(out_valid), 0, 0);
    check("R1 reset last", int'(out_last), 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle valid", int'(out_valid), 0, 0);
    for (int md = 0; md < 4; md++)
      for (int d = 1; d <= MAX_DEG; d++)
        for (int r = 0; r < 30; r++)
          run_row(d, md, r % 5);
    // R2: a row made only of the saturating code
    for (int i = 0; i < 4; i++) rv[i] = -32;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = (i == 0); in_last = (i == 3);
      in_msg = 6'h20; mode = 2'd3;
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      check("R2 all -32", int'($signed(out_msg)), expect_msg(4, k, 0), k);
    end
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule